// File: doc/BRIEF.md
# Lockable Copy-Back Data Cache

This block is a four-way set-associative data cache for 32-bit words. Its lines can be pinned by software. The processor side issues loads, stores and three maintenance commands. One command locks the line for an address. One releases a locked way in the set an address maps to. One drops the line for an address. The memory side carries line fills, write-backs of dirty victims, and single-word writes that go around the cache.

Locked ways never become victims. When a store misses in a set whose four ways are all pinned, it is not allocated: the word goes straight to memory. When a load misses in such a set, the line is read from memory without being installed. An invalidate discards the line without writing it back, even if the line is dirty. Two global inputs control behaviour. One enables the cache. The other selects copy-back mode; when it is low, the cache writes through and does not allocate on a store miss.

The geometry is 64 sets of 32-byte lines (8 words per line). The index is address bits [10:5] and the word select is bits [4:2]. Addresses that differ by a multiple of 0x800 share a set.

Top module: `lockable_dcache`

## Requirements
- R1: After reset every line is invalid and unlocked, `req_ready` is high, and `mem_valid` and `resp_valid` are low.
- R2: In copy-back mode (`copy_back`=1), a store that hits (`req_op`=1) updates only the cached word and marks the line dirty. It causes no memory transaction, and a later load (`req_op`=0) returns the new word.
- R3: A load miss issues one line read (`mem_kind`=0) at the line-aligned address and returns the word selected by address bits [4:2] from the fill data.
- R4: When the chosen victim is valid and dirty, a line write (`mem_kind`=1) of the victim to its own line address comes first, and the line read for the new address follows. Every stored value can therefore be read back.
- R5: A lock command (`req_op`=2) on an absent address fetches the line into an unlocked way and pins it. A lock on a resident line pins it without memory traffic. Later loads and stores to a locked line hit.
- R6: A store miss in a set whose four ways are all locked issues exactly one word write (`mem_kind`=2) at the store address and allocates nothing. A load miss in such a set reads the line without installing it.
- R7: An invalidate (`req_op`=4) on a resident line clears its valid, lock and dirty state with no memory transaction. A later load returns the memory contents.
- R8: An invalidate on a non-resident address causes no memory transaction and leaves memory unchanged.
- R9: An unlock (`req_op`=3) releases the way holding the addressed line if that way is locked. Otherwise it releases the lowest-numbered locked way of the set. Either way, the released way becomes a replacement candidate.
- R10: The victim is the lowest-numbered invalid way if one exists. Otherwise it is the first unlocked way found from a per-set round-robin pointer, which then moves to the way after the victim.
- R11: In write-through mode (`copy_back`=0), a store hit updates the line and also writes the word to memory. A store miss writes the word to memory without allocating.
- R12: With `cache_en`=0, loads read a line from memory uncached, stores write the word to memory, and maintenance commands have no effect.
- R13: `req_ready` is low while a memory transaction is open. Only one transaction is outstanding, and its address and kind hold until `mem_done`. `resp_valid` is a one-cycle pulse per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cache_en | input | 1 | Global cache enable |
| copy_back | input | 1 | 1 = copy-back stores, 0 = write-through |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_op | input | 3 | 0 load, 1 store, 2 lock, 3 unlock, 4 invalidate |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | Request completed (one cycle) |
| resp_rdata | output | 32 | Load data |
| mem_valid | output | 1 | Memory transaction open |
| mem_kind | output | 2 | 0 line read, 1 line write, 2 word write |
| mem_addr | output | 32 | Line address, or byte address for a word write |
| mem_wdata | output | 256 | Line data; a word write uses bits [31:0] |
| mem_done | input | 1 | Transaction complete (one cycle) |
| mem_rdata | input | 256 | Fill data, valid with mem_done |

## Verification
On a store miss, the line arrives from memory and the store word is merged into it in the same cycle. In that cycle the tag is installed and the dirty bit is set. A lock miss works the same way, except that the lock bit is set together with the install. The bench provokes this by storing to every word offset of more tags than a set has ways, so that each first touch of a tag is a merge during a fill and many fills follow a dirty write-back. It then reads every word back against values computed arithmetically from the address, and the transaction log confirms the order: write-back first, then fill.

// File: rtl/dcache_pkg.sv
// Shared encodings for the lockable data cache.
// Assumes: request and memory kind codes are fixed by the port contract.
package dcache_pkg;
    typedef enum logic [2:0] {
        OP_LOAD   = 3'd0,
        OP_STORE  = 3'd1,
        OP_LOCK   = 3'd2,
        OP_UNLOCK = 3'd3,
        OP_INVAL  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        MK_RD_LINE = 2'd0,
        MK_WR_LINE = 2'd1,
        MK_WR_WORD = 2'd2
    } memk_e;
endpackage

// File: rtl/dc_tag_match.sv
// Compares one tag against all ways of a set.
// Assumes: at most one valid way holds a given tag.
module dc_tag_match #(
    parameter int TAG_W = 21,
    parameter int WAYS  = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS*TAG_W-1:0] tags_flat,
    input  logic [WAYS-1:0]       valid,
    input  logic [TAG_W-1:0]      tag,
    output logic [WAYS-1:0]       hit_vec,
    output logic                  hit,
    output logic [WAY_W-1:0]      hit_way
);
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags_flat[g*TAG_W +: TAG_W] == tag);
    end

    assign hit = |hit_vec;

    // Encode the matching way number.
    always_comb begin
        hit_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hit_vec[i]) hit_way = WAY_W'(i);
        end
    end
endmodule

// File: rtl/dc_victim_pick.sv
// Chooses a replacement way: lowest invalid way first, else round-robin
// among unlocked ways starting at ptr. Flags when every way is locked.
// Assumes: invalid ways are never locked.
module dc_victim_pick #(
    parameter int WAYS = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]  valid,
    input  logic [WAYS-1:0]  lock,
    input  logic [WAY_W-1:0] ptr,
    output logic [WAY_W-1:0] way,
    output logic             none
);
    // Scan for an invalid way, then scan unlocked ways from the pointer.
    always_comb begin
        logic found;
        found = 1'b0;
        way   = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (!found && !valid[i] && !lock[i]) begin
                way   = WAY_W'(i);
                found = 1'b1;
            end
        end
        for (int k = 0; k < WAYS; k++) begin
            int j;
            j = (int'(ptr) + k) % WAYS;
            if (!found && !lock[j]) begin
                way   = WAY_W'(j);
                found = 1'b1;
            end
        end
        none = !found;
    end
endmodule

// File: rtl/dc_word_merge.sv
// Extracts one word from a line and optionally replaces it with new data.
// Assumes: sel addresses a word inside the line.
module dc_word_merge #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 8,
    localparam int WSEL_W = $clog2(WORDS),
    localparam int LINE_W = DATA_W * WORDS
) (
    input  logic [LINE_W-1:0] line_in,
    input  logic [WSEL_W-1:0] sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wen,
    output logic [LINE_W-1:0] line_out,
    output logic [DATA_W-1:0] word_out
);
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        assign line_out[g*DATA_W +: DATA_W] =
            (wen && (sel == WSEL_W'(g))) ? wdata : line_in[g*DATA_W +: DATA_W];
    end

    assign word_out = line_in[sel*DATA_W +: DATA_W];
endmodule

// File: rtl/lockable_dcache.sv
// Four-way set-associative data cache with per-line lock bits.
// Copy-back or write-through stores; locked ways are never replaced, and a
// store miss into a fully locked set bypasses to memory. Invalidate drops
// dirty data. One memory transaction at a time; requests stall meanwhile.
// Assumes: memory answers each transaction with a one-cycle mem_done.
module lockable_dcache
    import dcache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WORDS  = 8,
    parameter int SETS   = 64,
    parameter int WAYS   = 4,
    localparam int LINE_W = DATA_W * WORDS,
    localparam int BSEL_W = $clog2(DATA_W / 8),
    localparam int WSEL_W = $clog2(WORDS),
    localparam int OFF_W  = BSEL_W + WSEL_W,
    localparam int IDX_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              copy_back,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_valid,
    output logic [1:0]        mem_kind,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_done,
    input  logic [LINE_W-1:0] mem_rdata
);
    typedef enum logic [2:0] {
        S_IDLE, S_DECIDE, S_WB, S_FILL, S_BYP_RD, S_WORD_WR, S_RESP
    } state_e;

    state_e            state;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [WAY_W-1:0]  vic_q;
    logic [DATA_W-1:0] rdata_q;

    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [LINE_W-1:0] data_q  [SETS][WAYS];
    logic [WAYS-1:0]   val_q   [SETS];
    logic [WAYS-1:0]   dirty_q [SETS];
    logic [WAYS-1:0]   lock_q  [SETS];
    logic [WAY_W-1:0]  rr_q    [SETS];

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic [WSEL_W-1:0] wsel;
    assign idx  = addr_q[OFF_W +: IDX_W];
    assign tag  = addr_q[ADDR_W-1 -: TAG_W];
    assign wsel = addr_q[BSEL_W +: WSEL_W];

    logic [WAYS*TAG_W-1:0] tags_flat;
    for (genvar g = 0; g < WAYS; g++) begin : g_tags
        assign tags_flat[g*TAG_W +: TAG_W] = tag_q[idx][g];
    end

    logic [WAYS-1:0]  hit_vec;
    logic             hit;
    logic [WAY_W-1:0] hit_way;
    dc_tag_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_match (
        .tags_flat(tags_flat), .valid(val_q[idx]), .tag(tag),
        .hit_vec(hit_vec), .hit(hit), .hit_way(hit_way)
    );

    logic [WAY_W-1:0] vic_way;
    logic             vic_none;
    dc_victim_pick #(.WAYS(WAYS)) u_victim (
        .valid(val_q[idx]), .lock(lock_q[idx]), .ptr(rr_q[idx]),
        .way(vic_way), .none(vic_none)
    );

    logic              from_mem;
    logic [LINE_W-1:0] merge_in;
    logic [LINE_W-1:0] merged;
    logic [DATA_W-1:0] word_out;
    assign from_mem = (state == S_FILL) || (state == S_BYP_RD);
    assign merge_in = from_mem ? mem_rdata : data_q[idx][hit_way];
    dc_word_merge #(.DATA_W(DATA_W), .WORDS(WORDS)) u_merge (
        .line_in(merge_in), .sel(wsel), .wdata(wdata_q),
        .wen(op_q == OP_STORE), .line_out(merged), .word_out(word_out)
    );

    // Way released by an unlock: the addressed locked line, else lowest locked.
    logic [WAY_W-1:0] ul_way;
    always_comb begin
        ul_way = '0;
        if (hit && lock_q[idx][hit_way]) begin
            ul_way = hit_way;
        end else begin
            for (int i = WAYS - 1; i >= 0; i--) begin
                if (lock_q[idx][i]) ul_way = WAY_W'(i);
            end
        end
    end

    logic need_alloc;
    // Decide whether the latched request allocates a line in this cycle.
    always_comb begin
        need_alloc = 1'b0;
        if (state == S_DECIDE && cache_en && !hit && !vic_none) begin
            case (op_q)
                OP_LOAD, OP_LOCK: need_alloc = 1'b1;
                OP_STORE:         need_alloc = copy_back;
                default:          need_alloc = 1'b0;
            endcase
        end
    end

    // Control sequencing and per-line metadata.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            op_q    <= OP_LOAD;
            addr_q  <= '0;
            wdata_q <= '0;
            vic_q   <= '0;
            rdata_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                val_q[s]   <= '0;
                dirty_q[s] <= '0;
                lock_q[s]  <= '0;
                rr_q[s]    <= '0;
            end
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        op_q    <= op_e'(req_op);
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        state   <= S_DECIDE;
                    end
                end
                S_DECIDE: begin
                    if (need_alloc) begin
                        vic_q       <= vic_way;
                        rr_q[idx]   <= vic_way + WAY_W'(1);
                        state       <= (val_q[idx][vic_way] && dirty_q[idx][vic_way])
                                       ? S_WB : S_FILL;
                    end else if (!cache_en) begin
                        state <= (op_q == OP_LOAD)  ? S_BYP_RD :
                                 (op_q == OP_STORE) ? S_WORD_WR : S_RESP;
                    end else begin
                        state <= S_RESP;
                        case (op_q)
                            OP_LOAD: begin
                                if (hit) rdata_q <= word_out;
                                else     state   <= S_BYP_RD;
                            end
                            OP_STORE: begin
                                if (hit && copy_back) dirty_q[idx][hit_way] <= 1'b1;
                                if (!(hit && copy_back)) state <= S_WORD_WR;
                            end
                            OP_LOCK: begin
                                if (hit) lock_q[idx][hit_way] <= 1'b1;
                            end
                            OP_UNLOCK: begin
                                lock_q[idx][ul_way] <= 1'b0;
                            end
                            OP_INVAL: begin
                                if (hit) begin
                                    val_q[idx][hit_way]   <= 1'b0;
                                    lock_q[idx][hit_way]  <= 1'b0;
                                    dirty_q[idx][hit_way] <= 1'b0;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                S_WB: begin
                    if (mem_done) begin
                        dirty_q[idx][vic_q] <= 1'b0;
                        state               <= S_FILL;
                    end
                end
                S_FILL: begin
                    if (mem_done) begin
                        val_q[idx][vic_q]   <= 1'b1;
                        dirty_q[idx][vic_q] <= (op_q == OP_STORE);
                        lock_q[idx][vic_q]  <= (op_q == OP_LOCK);
                        rdata_q             <= word_out;
                        state               <= S_RESP;
                    end
                end
                S_BYP_RD: begin
                    if (mem_done) begin
                        rdata_q <= word_out;
                        state   <= S_RESP;
                    end
                end
                S_WORD_WR: begin
                    if (mem_done) state <= S_RESP;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Line data and tags: store-hit merge, or install on fill completion.
    always_ff @(posedge clk) begin
        if (state == S_DECIDE && cache_en && hit && op_q == OP_STORE) begin
            data_q[idx][hit_way] <= merged;
        end else if (state == S_FILL && mem_done) begin
            data_q[idx][vic_q] <= merged;
            tag_q[idx][vic_q]  <= tag;
        end
    end

    // Memory port drive, derived from the open transaction.
    always_comb begin
        memk_e k;
        k         = MK_RD_LINE;
        mem_addr  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        mem_wdata = '0;
        case (state)
            S_WB: begin
                k         = MK_WR_LINE;
                mem_addr  = {tag_q[idx][vic_q], idx, {OFF_W{1'b0}}};
                mem_wdata = data_q[idx][vic_q];
            end
            S_WORD_WR: begin
                k         = MK_WR_WORD;
                mem_addr  = addr_q;
                mem_wdata = LINE_W'(wdata_q);
            end
            default: ;
        endcase
        mem_kind = k;
    end

    assign mem_valid  = (state == S_WB) || (state == S_FILL) ||
                        (state == S_BYP_RD) || (state == S_WORD_WR);
    assign req_ready  = (state == S_IDLE);
    assign resp_valid = (state == S_RESP);
    assign resp_rdata = rdata_q;

    // R13: memory request held steady until completion
    a_r13_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_done) |=> (mem_valid && $stable(mem_addr) && $stable(mem_kind)));
    // R13: no request accepted while memory is busy
    a_r13_stall: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready);
    // R13: response is a single-cycle pulse
    a_r13_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
    // R4: a completed write-back is followed by the fill of the new line
    a_r4_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_kind == MK_WR_LINE && mem_done) |=> (mem_valid && mem_kind == MK_RD_LINE));
    // R10: a fill never lands in a locked way
    a_r10_fill_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FILL && mem_done) |-> !lock_q[idx][vic_q]);
    // R5: a lock bit only exists on a valid line
    a_r5_lock_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q[idx] & ~val_q[idx]) == '0);
    // R7: invalidate completes without memory traffic
    a_r7_inval_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DECIDE && cache_en && op_q == OP_INVAL) |=> !mem_valid);
    // R3: at most one way matches a tag
    a_r3_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: tb/test_lockable_dcache.sv
`timescale 1ns/1ps
module test_lockable_dcache;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         cache_en, copy_back;
    logic         req_valid;
    logic         req_ready;
    logic [2:0]   req_op;
    logic [31:0]  req_addr, req_wdata;
    logic         resp_valid;
    logic [31:0]  resp_rdata;
    logic         mem_valid;
    logic [1:0]   mem_kind;
    logic [31:0]  mem_addr;
    logic [255:0] mem_wdata;
    logic         mem_done;
    logic [255:0] mem_rdata;

    always #2 clk = ~clk;

    lockable_dcache i_lockable_dcache (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .copy_back(copy_back),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_valid(mem_valid), .mem_kind(mem_kind), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_done(mem_done), .mem_rdata(mem_rdata)
    );

    int errors = 0;
    int checks = 0;
    int ready_bad = 0;
    logic finished = 1'b0;

    logic [31:0] memw [int unsigned];
    int          log_n;
    logic [1:0]  log_k [16];
    logic [31:0] log_a [16];

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        if (memw.exists(a >> 2)) return memw[a >> 2];
        return 32'h0;
    endfunction

    function automatic logic [31:0] A(input int i);
        return 32'h0007_0000 + 32'(i) * 32'h2000;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_tx(input string req, input int idx, input logic [1:0] k, input logic [31:0] a);
        chk(req, {30'h0, log_k[idx]}, {30'h0, k});
        chk(req, log_a[idx], a);
    endtask

    // Behavioural backing memory with a fixed two-cycle latency.
    initial begin
        logic [1:0]  k;
        logic [31:0] a;
        mem_done  = 1'b0;
        mem_rdata = '0;
        log_n     = 0;
        forever begin
            @(negedge clk);
            mem_done = 1'b0;
            if (mem_valid) begin
                if (req_ready) ready_bad++;
                repeat (2) @(negedge clk);
                if (req_ready) ready_bad++;
                k = mem_kind;
                a = mem_addr;
                case (k)
                    2'd0: for (int w = 0; w < 8; w++) mem_rdata[w*32 +: 32] = rd_word(a + 32'(w*4));
                    2'd1: for (int w = 0; w < 8; w++) memw[(a >> 2) + 32'(w)] = mem_wdata[w*32 +: 32];
                    default: memw[a >> 2] = mem_wdata[31:0];
                endcase
                if (log_n < 16) begin
                    log_k[log_n] = k;
                    log_a[log_n] = a;
                end
                log_n++;
                mem_done = 1'b1;
            end
        end
    end

    task automatic do_req(input logic [2:0] op, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd);
        @(negedge clk);
        log_n     = 0;
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_valid) @(negedge clk);
        rd = resp_rdata;
        @(negedge clk);
        chk("R13 resp pulse", {31'h0, resp_valid}, 32'h0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [31:0] rd;
        rst_n = 1'b0; cache_en = 1'b1; copy_back = 1'b1;
        req_valid = 1'b0; req_op = 3'd0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        chk("R1 ready", {31'h0, req_ready}, 32'h1);
        chk("R1 mem_valid", {31'h0, mem_valid}, 32'h0);
        chk("R1 resp_valid", {31'h0, resp_valid}, 32'h0);
        rst_n = 1'b1;

        // Lock four lines of one set, then fill them with data.
        for (int i = 0; i < 4; i++) begin
            do_req(3'd2, A(i), 0, rd);
            chk("R5 lock fetch count", 32'(log_n), 32'd1);
            chk_tx("R3 R5 lock fetch", 0, 2'd0, A(i));
            do_req(3'd1, A(i), 32'h1111_1111 * 32'(i + 1), rd);
            chk("R2 store hit quiet", 32'(log_n), 32'd0);
        end
        for (int i = 0; i < 4; i++) begin
            do_req(3'd0, A(i), 0, rd);
            chk("R5 locked load", rd, 32'h1111_1111 * 32'(i + 1));
            chk("R2 load hit quiet", 32'(log_n), 32'd0);
        end
        do_req(3'd1, A(4), 32'hDEAD_BEEF, rd);
        chk("R6 bypass count", 32'(log_n), 32'd1);
        chk_tx("R6 bypass word", 0, 2'd2, A(4));
        chk("R6 memory word", rd_word(A(4)), 32'hDEAD_BEEF);
        chk("R2 copy-back kept locally", rd_word(A(0)), 32'h0);
        for (int n = 0; n < 2; n++) begin
            do_req(3'd0, A(4), 0, rd);
            chk("R6 load not installed", 32'(log_n), 32'd1);
            chk("R6 load value", rd, 32'hDEAD_BEEF);
        end

        // Invalidate discards dirty data; non-resident invalidate is harmless.
        for (int i = 0; i < 4; i++) begin
            do_req(3'd4, A(i), 0, rd);
            chk("R7 inval quiet", 32'(log_n), 32'd0);
        end
        do_req(3'd4, A(4), 0, rd);
        chk("R8 inval miss quiet", 32'(log_n), 32'd0);
        for (int i = 0; i < 4; i++) begin
            do_req(3'd0, A(i), 0, rd);
            chk("R7 dropped data", rd, 32'h0);
            chk("R7 refetch", 32'(log_n), 32'd1);
        end
        do_req(3'd0, A(4), 0, rd);
        chk("R8 memory kept", rd, 32'hDEAD_BEEF);
        chk("R10 clean victim no write-back", 32'(log_n), 32'd1);

        // Relock, then unlock a non-resident address: lowest locked way frees.
        for (int i = 1; i < 5; i++) do_req(3'd4, A(i), 0, rd);
        for (int i = 0; i < 4; i++) begin
            do_req(3'd2, A(i), 0, rd);
            do_req(3'd1, A(i), 32'h1111_1111 * 32'(i + 1), rd);
        end
        do_req(3'd3, A(4), 0, rd);
        chk("R9 unlock quiet", 32'(log_n), 32'd0);
        do_req(3'd1, A(5), 32'hBEEF_DEAD, rd);
        chk("R4 wb+fill count", 32'(log_n), 32'd2);
        chk_tx("R9 R4 write-back of way 0", 0, 2'd1, A(0));
        chk_tx("R4 fill after write-back", 1, 2'd0, A(5));
        chk("R4 written-back word", rd_word(A(0)), 32'h1111_1111);
        do_req(3'd3, A(2), 0, rd);
        do_req(3'd1, A(6), 32'h5555_5555, rd);
        chk_tx("R9 R10 resident unlock then pointer victim", 0, 2'd1, A(2));
        do_req(3'd0, A(0), 0, rd);
        chk("R4 readback A0", rd, 32'h1111_1111);
        chk_tx("R10 victim from pointer", 0, 2'd1, A(5));
        do_req(3'd0, A(1), 0, rd);
        chk("R5 still locked", 32'(log_n), 32'd0);
        chk("R5 readback A1", rd, 32'h2222_2222);
        do_req(3'd0, A(3), 0, rd);
        chk("R5 readback A3", rd, 32'h4444_4444);
        do_req(3'd0, A(2), 0, rd);
        chk("R4 readback A2", rd, 32'h3333_3333);
        do_req(3'd0, A(4), 0, rd);
        chk("R4 readback A4", rd, 32'hDEAD_BEEF);
        do_req(3'd0, A(5), 0, rd);
        chk("R4 readback A5", rd, 32'hBEEF_DEAD);
        do_req(3'd0, A(6), 0, rd);
        chk("R4 readback A6", rd, 32'h5555_5555);

        // Round-robin and invalid-first replacement in set 8.
        for (int t = 0; t < 8; t++)
            for (int w = 0; w < 8; w++)
                memw[(32'h100 + 32'(t) * 32'h800 + 32'(w * 4)) >> 2] =
                    32'hF000_0000 | (32'h100 + 32'(t) * 32'h800 + 32'(w * 4));
        for (int t = 0; t < 6; t++) begin
            do_req(3'd0, 32'h100 + 32'(t) * 32'h800 + 32'(t * 4), 0, rd);
            chk("R3 fill word", rd, 32'hF000_0000 | (32'h100 + 32'(t) * 32'h800 + 32'(t * 4)));
            chk_tx("R3 aligned fill", 0, 2'd0, 32'h100 + 32'(t) * 32'h800);
        end
        do_req(3'd0, 32'h100 + 32'h1000, 0, rd);
        chk("R10 T2 kept", 32'(log_n), 32'd0);
        do_req(3'd0, 32'h100 + 32'h1800, 0, rd);
        chk("R10 T3 kept", 32'(log_n), 32'd0);
        do_req(3'd4, 32'h100 + 32'h2000, 0, rd);
        do_req(3'd0, 32'h100 + 32'h3000, 0, rd);
        chk("R10 invalid-first fill", 32'(log_n), 32'd1);
        do_req(3'd0, 32'h100 + 32'h1000, 0, rd);
        chk("R10 T2 survives", 32'(log_n), 32'd0);
        do_req(3'd0, 32'h100 + 32'h2800, 0, rd);
        chk("R10 T5 survives", 32'(log_n), 32'd0);
        do_req(3'd0, 32'h100, 0, rd);
        chk("R10 T0 evicted", 32'(log_n), 32'd1);

        // Write-through mode.
        copy_back = 1'b0;
        do_req(3'd0, 32'h200, 0, rd);
        do_req(3'd1, 32'h200, 32'hA0A0_A0A0, rd);
        chk("R11 hit writes word", 32'(log_n), 32'd1);
        chk_tx("R11 hit word write", 0, 2'd2, 32'h200);
        chk("R11 memory updated", rd_word(32'h200), 32'hA0A0_A0A0);
        do_req(3'd0, 32'h200, 0, rd);
        chk("R11 line updated", rd, 32'hA0A0_A0A0);
        chk("R11 line hit", 32'(log_n), 32'd0);
        do_req(3'd1, 32'hA04, 32'hB1B1_B1B1, rd);
        chk_tx("R11 miss word write", 0, 2'd2, 32'hA04);
        do_req(3'd0, 32'hA04, 0, rd);
        chk_tx("R11 no allocate", 0, 2'd0, 32'hA00);
        chk("R11 miss value", rd, 32'hB1B1_B1B1);

        // Cache disabled.
        copy_back = 1'b1;
        cache_en  = 1'b0;
        do_req(3'd1, 32'h3E0, 32'hC3C3_C3C3, rd);
        chk_tx("R12 store to memory", 0, 2'd2, 32'h3E0);
        do_req(3'd0, 32'h3E0, 0, rd);
        chk("R12 uncached load", rd, 32'hC3C3_C3C3);
        chk_tx("R12 load line read", 0, 2'd0, 32'h3E0);
        do_req(3'd0, 32'h200, 0, rd);
        chk("R12 resident bypassed", 32'(log_n), 32'd1);
        do_req(3'd2, 32'h3E0, 0, rd);
        chk("R12 lock ignored", 32'(log_n), 32'd0);
        cache_en = 1'b1;
        do_req(3'd0, 32'h3E0, 0, rd);
        chk("R12 lock left no line", 32'(log_n), 32'd1);

        // Sweep: six tags x eight words in four sets, forcing dirty evictions.
        for (int pass = 0; pass < 2; pass++) begin
            for (int s = 40; s < 44; s++)
                for (int t = 0; t < 6; t++)
                    for (int w = 0; w < 8; w++) begin
                        logic [31:0] a;
                        a = 32'(s) * 32'h20 + 32'(t) * 32'h800 + 32'(w * 4);
                        if (pass == 0 || w % 2 == 1)
                            do_req(3'd1, a, a ^ (pass == 0 ? 32'h5A5A_0000 : 32'h0F0F_0F0F), rd);
                    end
            for (int s = 40; s < 44; s++)
                for (int t = 0; t < 6; t++)
                    for (int w = 0; w < 8; w++) begin
                        logic [31:0] a;
                        a = 32'(s) * 32'h20 + 32'(t) * 32'h800 + 32'(w * 4);
                        do_req(3'd0, a, 0, rd);
                        chk("R4 R2 sweep readback", rd,
                            a ^ ((pass == 1 && w % 2 == 1) ? 32'h0F0F_0F0F : 32'h5A5A_0000));
                    end
        end

        chk("R13 stall during memory", 32'(ready_bad), 32'd0);
        summary();
    end
endmodule